// File: doc/BRIEF.md
# Noise-Shaped Phase Direct Digital Synthesizer

This block is a direct digital frequency synthesis core. A 16-bit phase accumulator advances by a tuning word on every enabled clock. The upper 12 bits of that phase are then reduced to an 8-bit table address by an error-feedback quantizer. The quantizer works on phase, not on amplitude, and has a fourth-order noise transfer function. Truncation error is therefore pushed toward high frequencies, and a table addressed by 8 bits does the work of one addressed by 12 bits, at one sixteenth of the size.

The shaped address selects a signed 12-bit sine amplitude from a table built from a quarter wave by symmetry. The amplitude and the shaped address leave the block through an output register stage, together with a valid flag. That flag reproduces the enable input after the fixed pipeline delay `PIPE_LAT` (two cycles). A downstream converter or mixer takes one sample for each cycle in which the valid flag is high. Deasserting the enable freezes the phase and the shaper history, so the output holds its last value.

Top module: `dds_ns_core`

## Requirements
- R1: The accumulator is 16 bits wide. On each rising edge with `en_i` high it adds the registered tuning word and wraps modulo 65536, and a wrap produces no jump in the shaped phase beyond the normal error bound.
- R2: `fcw_i` is registered on every edge. A tuning word presented before edge k is first added to the accumulator at edge k+1.
- R3: While `en_i` is low, the accumulator, the shaper history and the shaped phase hold their values, so `phase_o` and `amp_o` stay constant.
- R4: Let x be accumulator bits [15:4] before the step, and let m1..m4 be the last four discarded nibbles, m1 the newest. At each enabled step the shaper forms v = (x + 4*m1 - 6*m2 + 4*m3 - m4) mod 4096. The shaped address is v[11:4], and the new nibble is v[3:0]. This gives a noise transfer function of (1 - z^-1)^4.
- R5: The shaped phase scaled by 16, minus x, taken as a signed 12-bit circular difference, stays within ±240 on every sample. Its sum over any run of consecutive samples also stays within ±240, so the mean error is zero.
- R6: `amp_o` is the two's complement value round(2047*sin(2*pi*(p+0.5)/256)) for shaped address p, rounded half away from zero. It never equals -2048.
- R7: `vld_o` is high exactly two edges after an edge that sampled `en_i` high. `phase_o` and `amp_o` in that cycle belong to that step.
- R8: While `rst_n` is low, all state is cleared: accumulator, tuning register, shaper history and shaped phase. The outputs read amplitude 0, address 0 and valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously upstream |
| en_i | input | 1 | Step enable for accumulator and shaper |
| fcw_i | input | 16 | Frequency tuning word |
| amp_o | output | 12 | Signed sine amplitude |
| phase_o | output | 8 | Shaped table address that produced `amp_o` |
| vld_o | output | 1 | Sample valid, enable delayed by the pipeline latency |

## Verification
The assertions assume that `rst_n` is released between clock edges and that `en_i` and `fcw_i` change only away from the rising edge. They accept any tuning word and any enable pattern. The bench drives every input on the falling edge, and it lowers reset only at a falling edge. Tuning words run from zero to full scale. Enable runs are continuous in some stretches and randomly gapped in others, so the error-bound and hold checks see wraps, stalls and word changes within those input conditions.

// File: rtl/dds_ns_pkg.sv
package dds_ns_pkg;

  // Binomial coefficient C(n, k), used to build the shaping filter taps
  function automatic int binom(input int n, input int k);
    int r;
    r = 1;
    for (int i = 1; i <= k; i++) r = r * (n - k + i) / i;
    return r;
  endfunction

  // Feedback tap weight applied to the discarded part delayed by 'tap' steps,
  // chosen so that the quantization noise sees (1 - z^-1)^order
  function automatic int shape_tap(input int order, input int tap);
    int c;
    c = binom(order, tap);
    return (tap % 2 == 1) ? c : -c;
  endfunction

endpackage

// File: rtl/dds_phase_acc.sv
module dds_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic [ACC_W-1:0] fcw_i,
  output logic [ACC_W-1:0] acc_o
);

  logic [ACC_W-1:0] fcw_q, fcw_d;
  logic [ACC_W-1:0] acc_q, acc_d;

  always_comb begin
    fcw_d = fcw_i;
    acc_d = en_i ? (acc_q + fcw_q) : acc_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fcw_q <= '0;
      acc_q <= '0;
    end else begin
      fcw_q <= fcw_d;
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/dds_phase_shaper.sv
module dds_phase_shaper
  import dds_ns_pkg::*;
#(
  parameter int PH_W   = 12,
  parameter int ADDR_W = 8,
  parameter int ORDER  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [PH_W-1:0]   x_i,
  output logic [ADDR_W-1:0] ph_o
);

  localparam int QB    = PH_W - ADDR_W;
  localparam int FB_W  = QB + ORDER + 2;
  localparam int SUM_W = ((FB_W > PH_W) ? FB_W : PH_W) + 1;

  logic [QB-1:0]           hist_q [ORDER];
  logic [QB-1:0]           hist_d [ORDER];
  logic [ADDR_W-1:0]       ph_q, ph_d;
  logic signed [SUM_W-1:0] tap_term [ORDER];
  logic signed [SUM_W-1:0] fb_sum;
  logic signed [SUM_W-1:0] v_full;
  logic [PH_W-1:0]         v_mod;

  // One weighted term per delayed discarded part
  for (genvar t = 0; t < ORDER; t++) begin : g_tap
    localparam int COEF = shape_tap(ORDER, t + 1);
    logic signed [SUM_W-1:0] coef_s;
    logic signed [SUM_W-1:0] part_s;
    assign coef_s      = SUM_W'(COEF);
    assign part_s      = $signed({{(SUM_W-QB){1'b0}}, hist_q[t]});
    assign tap_term[t] = coef_s * part_s;
  end

  always_comb begin
    fb_sum = '0;
    for (int t = 0; t < ORDER; t++) fb_sum = fb_sum + tap_term[t];
    v_full = $signed({{(SUM_W-PH_W){1'b0}}, x_i}) + fb_sum;
    v_mod  = v_full[PH_W-1:0];   // wrap around the phase circle
  end

  always_comb begin
    ph_d      = en_i ? v_mod[PH_W-1 -: ADDR_W] : ph_q;
    hist_d[0] = en_i ? v_mod[QB-1:0] : hist_q[0];
    for (int t = 1; t < ORDER; t++) hist_d[t] = en_i ? hist_q[t-1] : hist_q[t];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q <= '0;
      for (int t = 0; t < ORDER; t++) hist_q[t] <= '0;
    end else begin
      ph_q <= ph_d;
      for (int t = 0; t < ORDER; t++) hist_q[t] <= hist_d[t];
    end
  end

  assign ph_o = ph_q;

endmodule

// File: rtl/dds_sine_rom.sv
module dds_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [AMP_W-1:0]  amp_o
);

  localparam int  QW    = ADDR_W - 2;
  localparam int  QN    = 2 ** QW;
  localparam real SCALE = real'(2 ** (AMP_W - 1) - 1);
  localparam real PI_C  = 3.14159265358979;

  logic [AMP_W-1:0] qtab [QN];

  // Quarter wave sampled at half-step offsets so mirroring is exact
  for (genvar i = 0; i < QN; i++) begin : g_quarter
    localparam real ANG = 2.0 * PI_C * (real'(i) + 0.5) / real'(4 * QN);
    localparam int  QV  = $rtoi(SCALE * $sin(ANG) + 0.5);
    assign qtab[i] = AMP_W'(QV);
  end

  logic [1:0]       quad;
  logic [QW-1:0]    idx, idx_eff;
  logic [AMP_W-1:0] mag;

  always_comb begin
    quad    = addr_i[ADDR_W-1 -: 2];
    idx     = addr_i[QW-1:0];
    idx_eff = quad[0] ? ~idx : idx;
    mag     = qtab[idx_eff];
    amp_o   = quad[1] ? (~mag + 1'b1) : mag;
  end

endmodule

// File: rtl/dds_ns_core.sv
module dds_ns_core #(
  parameter int ACC_W  = 16,
  parameter int PH_W   = 12,
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12,
  parameter int ORDER  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_i,
  input  logic [ACC_W-1:0]  fcw_i,
  output logic [AMP_W-1:0]  amp_o,
  output logic [ADDR_W-1:0] phase_o,
  output logic              vld_o
);

  // Enable-to-valid delay: shaper register plus output register
  localparam int PIPE_LAT = 2;

  logic [ACC_W-1:0]  acc_w;
  logic [ADDR_W-1:0] ph_w;
  logic [AMP_W-1:0]  rom_amp;

  dds_phase_acc #(.ACC_W(ACC_W)) acc_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (en_i),
    .fcw_i (fcw_i),
    .acc_o (acc_w)
  );

  dds_phase_shaper #(.PH_W(PH_W), .ADDR_W(ADDR_W), .ORDER(ORDER)) shp_i (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (en_i),
    .x_i   (acc_w[ACC_W-1 -: PH_W]),
    .ph_o  (ph_w)
  );

  dds_sine_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) rom_i (
    .addr_i (ph_w),
    .amp_o  (rom_amp)
  );

  logic [AMP_W-1:0]    amp_q, amp_d;
  logic [ADDR_W-1:0]   pho_q, pho_d;
  logic [PIPE_LAT-1:0] vpipe_q, vpipe_d;

  always_comb begin
    amp_d   = rom_amp;
    pho_d   = ph_w;
    vpipe_d = {vpipe_q[PIPE_LAT-2:0], en_i};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      amp_q   <= '0;
      pho_q   <= '0;
      vpipe_q <= '0;
    end else begin
      amp_q   <= amp_d;
      pho_q   <= pho_d;
      vpipe_q <= vpipe_d;
    end
  end

  assign amp_o   = amp_q;
  assign phase_o = pho_q;
  assign vld_o   = vpipe_q[PIPE_LAT-1];

endmodule

// File: rtl/dds_ns_core_chk.sv
module dds_ns_core_chk #(
  parameter int ACC_W  = 16,
  parameter int PH_W   = 12,
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 12,
  parameter int ORDER  = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en_i,
  input logic [ACC_W-1:0]  fcw_i,
  input logic [ACC_W-1:0]  acc,
  input logic [ADDR_W-1:0] ph,
  input logic [AMP_W-1:0]  amp_o,
  input logic              vld_o
);

  localparam int QB    = PH_W - ADDR_W;
  localparam int BOUND = (2 ** ORDER) * (2 ** QB - 1);

  logic [1:0]      since_q;
  logic [PH_W-1:0] x_w;

  assign x_w = acc[ACC_W-1 -: PH_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              since_q <= '0;
    else if (since_q != 2'd3) since_q <= since_q + 2'd1;
  end

  function automatic logic in_bound(input logic [ADDR_W-1:0] p, input logic [PH_W-1:0] x);
    logic signed [PH_W-1:0] d;
    d = $signed({p, {QB{1'b0}}} - x);
    return (d <= BOUND) && (d >= -BOUND);
  endfunction

  AST_ACC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 2'd2 && $past(en_i)) |-> acc == $past(acc) + $past(fcw_i, 2)); // R2

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> ($stable(acc) && $stable(ph))); // R3

  AST_PHASE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q >= 2'd1 && $past(en_i)) |-> in_bound(ph, $past(x_w))); // R5

  AST_VLD_LAT: assert property (@(posedge clk) disable iff (!rst_n)
    (since_q == 2'd3) |-> (vld_o == $past(en_i, 2))); // R7

  AST_AMP_SYM: assert property (@(posedge clk) disable iff (!rst_n)
    amp_o != {1'b1, {(AMP_W-1){1'b0}}}); // R6

endmodule

bind dds_ns_core dds_ns_core_chk #(
  .ACC_W(ACC_W), .PH_W(PH_W), .ADDR_W(ADDR_W), .AMP_W(AMP_W), .ORDER(ORDER)
) chk_i (
  .clk   (clk),
  .rst_n (rst_n),
  .en_i  (en_i),
  .fcw_i (fcw_i),
  .acc   (acc_w),
  .ph    (ph_w),
  .amp_o (amp_o),
  .vld_o (vld_o)
);

// File: tb/dds_ns_core_tb_top.sv
module dds_ns_core_tb_top;

  logic        clk;
  logic        rst_n;
  logic        en_i;
  logic [15:0] fcw_i;
  logic [11:0] amp_o;
  logic [7:0]  phase_o;
  logic        vld_o;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dds_ns_core dut_i (
    .clk(clk), .rst_n(rst_n), .en_i(en_i), .fcw_i(fcw_i),
    .amp_o(amp_o), .phase_o(phase_o), .vld_o(vld_o)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // Reference model state, advanced at each rising edge from bench-driven inputs
  int m_fcw, m_acc, m_h0, m_h1, m_h2, m_h3, m_ph, m_xs, m_v1;
  int m_pho, m_amp, m_vld, m_xo;

  function automatic int sine_ref(input int p);
    real s;
    s = 2047.0 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 256.0);
    return (s >= 0.0) ? $rtoi(s + 0.5) : -$rtoi(-s + 0.5);
  endfunction

  function automatic int wrap12(input int d);
    int w;
    w = d & 4095;
    return (w >= 2048) ? w - 4096 : w;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fcw = 0; m_acc = 0; m_h0 = 0; m_h1 = 0; m_h2 = 0; m_h3 = 0;
      m_ph = 0; m_xs = 0; m_v1 = 0; m_pho = 0; m_amp = 0; m_vld = 0; m_xo = 0;
    end else begin
      int x, v;
      m_amp = sine_ref(m_ph) & 4095;
      m_pho = m_ph;
      m_vld = m_v1;
      m_xo  = m_xs;
      if (en_i) begin
        x     = (m_acc >> 4) & 4095;
        v     = (x + 4*m_h0 - 6*m_h1 + 4*m_h2 - m_h3) & 4095;
        m_ph  = v >> 4;
        m_h3  = m_h2; m_h2 = m_h1; m_h1 = m_h0; m_h0 = v & 15;
        m_xs  = x;
        m_acc = (m_acc + m_fcw) & 65535;
      end
      m_v1  = en_i;
      m_fcw = fcw_i;
    end
  end

  string tag = "R8";
  bit    mean_on = 0;
  int    err_sum = 0;

  task automatic check(input string req, input int act, input int exp_v);
    checks++;
    if (act != exp_v) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
    end
  endtask

  task automatic sample_checks();
    check({tag, "/R7 valid"}, vld_o, m_vld);
    check({tag, "/R4 phase"}, phase_o, m_pho);
    check({tag, "/R6 amplitude"}, amp_o, m_amp);
    if (mean_on && vld_o) begin
      int d;
      d = wrap12(int'(phase_o) * 16 - m_xo);
      err_sum += d;
      check("R5 sample bound", (d <= 240 && d >= -240) ? 1 : 0, 1);
    end
  endtask

  task automatic step(input bit en, input int fcw);
    @(negedge clk);
    sample_checks();
    en_i  = en;
    fcw_i = 16'(fcw);
  endtask

  initial begin
    void'($urandom(32'h5eed_0d55));
    rst_n = 1'b0; en_i = 1'b0; fcw_i = '0;
    repeat (3) @(negedge clk);
    // R8: reset state at the ports
    check("R8 reset amp", amp_o, 0);
    check("R8 reset phase", phase_o, 0);
    check("R8 reset valid", vld_o, 0);
    rst_n = 1'b1;

    // R7 / R4: directed steady run
    tag = "R7";
    for (int i = 0; i < 20; i++) step(1'b1, 16'h0123);
    // R2: tuning word change in mid-run
    tag = "R2";
    for (int i = 0; i < 20; i++) step(1'b1, 16'h7FF1);
    // R3: enable gaps, outputs must freeze
    tag = "R3";
    for (int i = 0; i < 40; i++) step((i % 5) < 2, 16'h0431 + i);
    begin
      int held;
      step(1'b0, 16'h1111);
      step(1'b0, 16'h2222);
      step(1'b0, 16'h3333);
      held = phase_o;
      step(1'b0, 16'h4444);
      check("R3 phase frozen", phase_o, held);
    end
    // R1: accumulator wraps at near-full-scale and half-scale words
    tag = "R1";
    mean_on = 1; err_sum = 0;
    for (int i = 0; i < 200; i++) step(1'b1, 16'hFFF0);
    for (int i = 0; i < 200; i++) step(1'b1, 16'h8000);
    for (int i = 0; i < 200; i++) step(1'b1, 16'h0000);
    mean_on = 0;
    // R5: long run, mean error stays bounded
    tag = "R5";
    for (int n = 0; n < 3; n++) begin
      int w;
      w = int'($urandom_range(1, 65535));
      mean_on = 1; err_sum = 0;
      for (int i = 0; i < 1500; i++) step(1'b1, w);
      check("R5 mean error", (err_sum <= 240 && err_sum >= -240) ? 1 : 0, 1);
    end
    mean_on = 0;
    // R4 / R6: random words and random enable
    tag = "R4";
    for (int i = 0; i < 2000; i++) begin
      int w;
      w = (i % 50 == 0) ? int'($urandom) : int'(fcw_i);
      step(($urandom_range(0, 3) != 0), w);
    end
    // R8: reset in mid-run
    tag = "R8";
    @(negedge clk);
    sample_checks();
    rst_n = 1'b0;
    en_i  = 1'b1;
    @(negedge clk);
    check("R8 mid reset amp", amp_o, 0);
    check("R8 mid reset phase", phase_o, 0);
    check("R8 mid reset valid", vld_o, 0);
    en_i  = 1'b0;
    rst_n = 1'b1;
    for (int i = 0; i < 10; i++) step(1'b1, 16'h0500);
    step(1'b0, 16'h0500);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule